// File: doc/BRIEF.md
# Dual-Clock Block Memory

A 4096-bit on-chip memory with two access ports, A and B, each running on its own clock. The word width is fixed at elaboration by `DATA_W`. It must be one of 1, 2, 4, 8, 9, 16, 18, 32 or 36. The depth follows from the width: 4096 divided by the width, except for the 9-, 18- and 36-bit shapes. Those shapes count only 8 of every 9 bits against the 4096, so 512×9, 256×18 and 128×36 give each byte lane a ninth bit. On shapes of 8 bits or more, each 8-bit lane (9-bit on the parity shapes) has its own write-enable bit. Narrower shapes always write the whole word.

With `TRUE_DP` set, both ports read and write. In that mode the 32- and 36-bit shapes are refused at elaboration. With `TRUE_DP` clear, port A only writes, port B only reads, writes on B are dropped, `rdata_a_o` stays zero, and the wide shapes are allowed. Each port samples its address, data and controls at its rising clock edge. Each port has a parameter that adds an output register, which raises its read latency from one clock to two. The stored result is undefined when both ports write the same address on coinciding edges; users must avoid that case.

Top module: `dual_clk_bram`

## Requirements
- R1: While `rst_ni` is low, and after its release until the first enabled read, `rdata_a_o` and `rdata_b_o` are 0.
- R2: With the default `DATA_W` = 18, the memory holds 256 independent words. Each word has lane 0 in bits [8:0] and lane 1 in bits [17:9]. Writing a distinct value to every address and reading all of them back returns each value unchanged.
- R3: A write sampled at edge k (`en`=1, `we`=1) is returned by a read of the same address sampled on the same port at edge k+1.
- R4: A read sampled at edge k appears on `rdata_a_o` right after edge k, because port A has no output register (`OUT_REG_A`=0). It appears on `rdata_b_o` right after edge k+1, because port B has the output register (`OUT_REG_B`=1).
- R5: An access with `en`=1 and `we`=1 also reads. It returns the word as it was before that write.
- R6: Bit l of `be` enables lane l, and this covers the lane's ninth bit. Lanes whose enable bit is 0 keep their contents. With `be`=0 nothing changes.
- R7: A word written on either port is read back on the other port after the writing edge. The two ports run concurrently on unrelated clocks without disturbing each other's addresses.
- R8: With `en`=0 a port neither writes, whatever `we`, `be` and data are, nor changes its `rdata`.
- R9: When the two ports write the same address at different times, each lane holds the value from the later write to that lane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a_i | input | 1 | Port A clock |
| clk_b_i | input | 1 | Port B clock |
| rst_ni | input | 1 | Asynchronous active-low reset of the read registers |
| en_a_i | input | 1 | Port A access enable |
| we_a_i | input | 1 | Port A write (with en) |
| be_a_i | input | LANES | Port A lane write enables |
| addr_a_i | input | AW | Port A word address |
| wdata_a_i | input | DATA_W | Port A write data |
| rdata_a_o | output | DATA_W | Port A read data |
| en_b_i | input | 1 | Port B access enable |
| we_b_i | input | 1 | Port B write (with en) |
| be_b_i | input | LANES | Port B lane write enables |
| addr_b_i | input | AW | Port B word address |
| wdata_b_i | input | DATA_W | Port B write data |
| rdata_b_o | output | DATA_W | Port B read data |

## Verification
The memory keeps two banks and a per-lane record of which port wrote last. A wrong record shows up on the very next read of that address. It appears as a whole lane holding the other port's older value, one clock later on port A and two clocks later on port B. A wrong read register or output register shows up on the following read as stale or early data. It also shows up as an output that moves while the port is disabled. The bench's model predicts both outputs on every clock. It therefore catches these faults on the first affected read, not later in an accumulated result.

// File: rtl/dcb_pkg.sv
package dcb_pkg;
  localparam int unsigned NRD = 2;  // read paths: 0 = port A, 1 = port B

  function automatic bit shape_ok(int unsigned w);
    return w inside {1, 2, 4, 8, 9, 16, 18, 32, 36};
  endfunction

  function automatic bit parity_shape(int unsigned w);
    return (w % 9) == 0;
  endfunction

  function automatic int unsigned lane_w(int unsigned w);
    if (w < 8) return w;
    return parity_shape(w) ? 9 : 8;
  endfunction

  function automatic int unsigned depth_of(int unsigned bits, int unsigned w);
    int unsigned core_w;
    core_w = parity_shape(w) ? (w / 9) * 8 : w;
    return bits / core_w;
  endfunction
endpackage

// File: rtl/dcb_bank.sv
module dcb_bank
  import dcb_pkg::*;
#(
  parameter int unsigned DEPTH = 256,
  parameter int unsigned AW    = 8,
  parameter int unsigned LANES = 2,
  parameter int unsigned LW    = 9,
  localparam int unsigned W    = LANES * LW
) (
  input  logic                       clk_i,
  input  logic [LANES-1:0]           lane_we_i,
  input  logic [AW-1:0]              waddr_i,
  input  logic [W-1:0]               wdata_i,
  input  logic [LANES-1:0]           tag_d_i,
  input  logic [NRD-1:0][AW-1:0]     raddr_i,
  output logic [NRD-1:0][W-1:0]      rdata_o,
  output logic [NRD-1:0][LANES-1:0]  rtag_o
);
  logic [LANES-1:0][LW-1:0] mem_q [DEPTH];
  logic [LANES-1:0]         tag_q [DEPTH];

  always_ff @(posedge clk_i) begin
    for (int l = 0; l < LANES; l++) begin
      if (lane_we_i[l]) begin
        mem_q[waddr_i][l] <= wdata_i[l*LW +: LW];
        tag_q[waddr_i][l] <= tag_d_i[l];
      end
    end
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    assign rdata_o[p] = mem_q[raddr_i[p]];
    assign rtag_o[p]  = tag_q[raddr_i[p]];
  end
endmodule

// File: rtl/dcb_rd_port.sv
module dcb_rd_port #(
  parameter int unsigned W       = 18,
  parameter bit          OUT_REG = 1'b0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic [W-1:0] word_i,
  output logic [W-1:0] rdata_o
);
  logic [W-1:0] rd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rd_q <= '0;
    else if (en_i) rd_q <= word_i;
  end

  if (OUT_REG) begin : g_oreg
    logic [W-1:0] out_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) out_q <= '0;
      else         out_q <= rd_q;
    end
    assign rdata_o = out_q;
  end else begin : g_noreg
    assign rdata_o = rd_q;
  end
endmodule

// File: rtl/dual_clk_bram.sv
module dual_clk_bram
  import dcb_pkg::*;
#(
  parameter int unsigned MEM_BITS  = 4096,
  parameter int unsigned DATA_W    = 18,
  parameter bit          TRUE_DP   = 1'b1,
  parameter bit          OUT_REG_A = 1'b0,
  parameter bit          OUT_REG_B = 1'b1,
  localparam int unsigned LW    = lane_w(DATA_W),
  localparam int unsigned LANES = DATA_W / LW,
  localparam int unsigned DEPTH = depth_of(MEM_BITS, DATA_W),
  localparam int unsigned AW    = $clog2(DEPTH)
) (
  input  logic              clk_a_i,
  input  logic              clk_b_i,
  input  logic              rst_ni,
  input  logic              en_a_i,
  input  logic              we_a_i,
  input  logic [LANES-1:0]  be_a_i,
  input  logic [AW-1:0]     addr_a_i,
  input  logic [DATA_W-1:0] wdata_a_i,
  output logic [DATA_W-1:0] rdata_a_o,
  input  logic              en_b_i,
  input  logic              we_b_i,
  input  logic [LANES-1:0]  be_b_i,
  input  logic [AW-1:0]     addr_b_i,
  input  logic [DATA_W-1:0] wdata_b_i,
  output logic [DATA_W-1:0] rdata_b_o
);
  if (!shape_ok(DATA_W)) begin : g_bad_width
    $error("dual_clk_bram: DATA_W %0d is not a supported shape", DATA_W);
  end
  if (TRUE_DP && DATA_W >= 32) begin : g_bad_mode
    $error("dual_clk_bram: %0d-bit shape needs one write-only port", DATA_W);
  end

  logic [NRD-1:0][AW-1:0]     raddr;
  logic [NRD-1:0][DATA_W-1:0] dat_a, dat_b, word;
  logic [NRD-1:0][LANES-1:0]  tag_a, tag_b, sel;
  logic [LANES-1:0]           lane_we_a, tag_d_a;

  assign raddr   = {addr_b_i, addr_a_i};
  assign tag_d_a = tag_b[0];  // A write: make tags equal

  // narrow shapes write the whole word
  always_comb begin
    lane_we_a = '0;
    if (en_a_i && we_a_i) lane_we_a = (DATA_W < 8) ? '1 : be_a_i;
  end

  dcb_bank #(.DEPTH(DEPTH), .AW(AW), .LANES(LANES), .LW(LW)) u_bank_a (
    .clk_i     (clk_a_i),
    .lane_we_i (lane_we_a),
    .waddr_i   (addr_a_i),
    .wdata_i   (wdata_a_i),
    .tag_d_i   (tag_d_a),
    .raddr_i   (raddr),
    .rdata_o   (dat_a),
    .rtag_o    (tag_a)
  );

  if (TRUE_DP) begin : g_tdp
    logic [LANES-1:0] lane_we_b, tag_d_b;
    assign tag_d_b = ~tag_a[1];  // B write: make tags differ
    always_comb begin
      lane_we_b = '0;
      if (en_b_i && we_b_i) lane_we_b = (DATA_W < 8) ? '1 : be_b_i;
    end

    dcb_bank #(.DEPTH(DEPTH), .AW(AW), .LANES(LANES), .LW(LW)) u_bank_b (
      .clk_i     (clk_b_i),
      .lane_we_i (lane_we_b),
      .waddr_i   (addr_b_i),
      .wdata_i   (wdata_b_i),
      .tag_d_i   (tag_d_b),
      .raddr_i   (raddr),
      .rdata_o   (dat_b),
      .rtag_o    (tag_b)
    );
    assign sel = tag_a ^ tag_b;

    dcb_rd_port #(.W(DATA_W), .OUT_REG(OUT_REG_A)) u_rd_a (
      .clk_i   (clk_a_i),
      .rst_ni  (rst_ni),
      .en_i    (en_a_i),
      .word_i  (word[0]),
      .rdata_o (rdata_a_o)
    );
  end else begin : g_sdp
    assign dat_b     = '0;
    assign tag_b     = '0;
    assign sel       = '0;
    assign rdata_a_o = '0;
  end

  // per-lane pick of the bank written last
  always_comb begin
    for (int p = 0; p < NRD; p++) begin
      for (int l = 0; l < LANES; l++) begin
        word[p][l*LW +: LW] = sel[p][l] ? dat_b[p][l*LW +: LW] : dat_a[p][l*LW +: LW];
      end
    end
  end

  dcb_rd_port #(.W(DATA_W), .OUT_REG(OUT_REG_B)) u_rd_b (
    .clk_i   (clk_b_i),
    .rst_ni  (rst_ni),
    .en_i    (en_b_i),
    .word_i  (word[1]),
    .rdata_o (rdata_b_o)
  );
endmodule

// File: rtl/dcb_chk.sv
module dcb_port_chk #(
  parameter int unsigned W       = 18,
  parameter int unsigned AW      = 8,
  parameter int unsigned LANES   = 2,
  parameter bit          OUT_REG = 1'b0,
  parameter bit          WR_OK   = 1'b1
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             en_i,
  input logic             we_i,
  input logic [LANES-1:0] be_i,
  input logic [AW-1:0]    addr_i,
  input logic [W-1:0]     wdata_i,
  input logic [W-1:0]     rdata_i
);
  logic [1:0] age_q;
  logic       full_wr;

  assign full_wr = en_i & we_i & (&be_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             age_q <= '0;
    else if (age_q != 2'd3)  age_q <= age_q + 2'd1;
  end

  // R1
  rst_zero_chk: assert property (@(posedge clk_i) !rst_ni |-> rdata_i == '0);

  if (!OUT_REG) begin : g_lat1
    // R8
    hold_lat1_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (age_q >= 2'd2 && !$past(en_i)) |-> $stable(rdata_i));
    if (WR_OK) begin : g_wr
      // R3 R4 R5
      wr_rd_lat1_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (age_q == 2'd3 && $past(full_wr, 2) && $past(en_i, 1) &&
         $past(addr_i, 1) == $past(addr_i, 2)) |-> rdata_i == $past(wdata_i, 2));
    end
  end else begin : g_lat2
    // R8
    hold_lat2_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (age_q >= 2'd2 && !$past(en_i, 1) && !$past(en_i, 2)) |-> $stable(rdata_i));
    if (WR_OK) begin : g_wr
      // R3 R4 R5
      wr_rd_lat2_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (age_q == 2'd3 && $past(full_wr, 3) && $past(en_i, 2) &&
         $past(addr_i, 2) == $past(addr_i, 3)) |-> rdata_i == $past(wdata_i, 3));
    end
  end
endmodule

module dcb_chk #(
  parameter int unsigned W         = 18,
  parameter int unsigned AW        = 8,
  parameter int unsigned LANES     = 2,
  parameter bit          TRUE_DP   = 1'b1,
  parameter bit          OUT_REG_A = 1'b0,
  parameter bit          OUT_REG_B = 1'b1
) (
  input logic             clk_a_i,
  input logic             clk_b_i,
  input logic             rst_ni,
  input logic             en_a_i,
  input logic             we_a_i,
  input logic [LANES-1:0] be_a_i,
  input logic [AW-1:0]    addr_a_i,
  input logic [W-1:0]     wdata_a_i,
  input logic [W-1:0]     rdata_a_o,
  input logic             en_b_i,
  input logic             we_b_i,
  input logic [LANES-1:0] be_b_i,
  input logic [AW-1:0]    addr_b_i,
  input logic [W-1:0]     wdata_b_i,
  input logic [W-1:0]     rdata_b_o
);
  if (TRUE_DP) begin : g_a
    dcb_port_chk #(.W(W), .AW(AW), .LANES(LANES), .OUT_REG(OUT_REG_A), .WR_OK(1'b1)) u_a (
      .clk_i(clk_a_i), .rst_ni(rst_ni), .en_i(en_a_i), .we_i(we_a_i), .be_i(be_a_i),
      .addr_i(addr_a_i), .wdata_i(wdata_a_i), .rdata_i(rdata_a_o)
    );
  end

  dcb_port_chk #(.W(W), .AW(AW), .LANES(LANES), .OUT_REG(OUT_REG_B), .WR_OK(TRUE_DP)) u_b (
    .clk_i(clk_b_i), .rst_ni(rst_ni), .en_i(en_b_i), .we_i(we_b_i), .be_i(be_b_i),
    .addr_i(addr_b_i), .wdata_i(wdata_b_i), .rdata_i(rdata_b_o)
  );
endmodule

bind dual_clk_bram dcb_chk #(
  .W(DATA_W), .AW(AW), .LANES(LANES), .TRUE_DP(TRUE_DP),
  .OUT_REG_A(OUT_REG_A), .OUT_REG_B(OUT_REG_B)
) u_dcb_chk (
  .clk_a_i(clk_a_i), .clk_b_i(clk_b_i), .rst_ni(rst_ni),
  .en_a_i(en_a_i), .we_a_i(we_a_i), .be_a_i(be_a_i), .addr_a_i(addr_a_i),
  .wdata_a_i(wdata_a_i), .rdata_a_o(rdata_a_o),
  .en_b_i(en_b_i), .we_b_i(we_b_i), .be_b_i(be_b_i), .addr_b_i(addr_b_i),
  .wdata_b_i(wdata_b_i), .rdata_b_o(rdata_b_o)
);

// File: tb/dual_clk_bram_bench.sv
module dual_clk_bram_bench;
  localparam int CLK_A_PERIOD = 10;
  localparam int CLK_B_HALF   = 7;
  localparam int W     = 18;
  localparam int LW    = 9;
  localparam int LANES = 2;
  localparam int DEPTH = 256;
  localparam int AW    = 8;
  localparam bit OREG_A = 1'b0;
  localparam bit OREG_B = 1'b1;

  logic clk_a = 1'b0, clk_b = 1'b0, rst_n = 1'b1;
  logic en_a = 0, we_a = 0, en_b = 0, we_b = 0;
  logic [LANES-1:0] be_a = '0, be_b = '0;
  logic [AW-1:0] addr_a = '0, addr_b = '0;
  logic [W-1:0] wdata_a = '0, wdata_b = '0, rdata_a, rdata_b;

  int checks = 0, fails = 0;
  string cur_req = "R1";

  // A rises at odd multiples of 5, B at 8+14m: never together
  always #(CLK_A_PERIOD/2) clk_a = ~clk_a;
  initial begin #1; forever #(CLK_B_HALF) clk_b = ~clk_b; end

  dual_clk_bram #(.DATA_W(W), .TRUE_DP(1'b1), .OUT_REG_A(OREG_A), .OUT_REG_B(OREG_B)) u_dual_clk_bram (
    .clk_a_i(clk_a), .clk_b_i(clk_b), .rst_ni(rst_n),
    .en_a_i(en_a), .we_a_i(we_a), .be_a_i(be_a), .addr_a_i(addr_a),
    .wdata_a_i(wdata_a), .rdata_a_o(rdata_a),
    .en_b_i(en_b), .we_b_i(we_b), .be_b_i(be_b), .addr_b_i(addr_b),
    .wdata_b_i(wdata_b), .rdata_b_o(rdata_b)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s at %0t: actual=%h expected=%h", req, what, $time, act, exp);
    end
  endtask

  // behavioural reference
  logic [W-1:0] mem_m [DEPTH];
  bit           known_m [DEPTH];
  logic [W-1:0] rq_a, exp_a, rq_b, exp_b;
  bit           rqk_a, expk_a, rqk_b, expk_b;

  initial for (int i = 0; i < DEPTH; i++) known_m[i] = 0;

  always @(posedge clk_a or negedge rst_n) begin
    logic [W-1:0] nxt;
    bit nk;
    if (!rst_n) begin
      rq_a = '0; exp_a = '0; rqk_a = 1; expk_a = 1;
    end else begin
      nxt = rq_a; nk = rqk_a;
      if (en_a) begin nxt = mem_m[addr_a]; nk = known_m[addr_a]; end
      if (en_a && we_a) begin
        for (int l = 0; l < LANES; l++)
          if (be_a[l]) mem_m[addr_a][l*LW +: LW] = wdata_a[l*LW +: LW];
        if (&be_a) known_m[addr_a] = 1;
      end
      if (OREG_A) begin exp_a = rq_a; expk_a = rqk_a; end
      else        begin exp_a = nxt;  expk_a = nk;    end
      rq_a = nxt; rqk_a = nk;
    end
  end

  always @(posedge clk_b or negedge rst_n) begin
    logic [W-1:0] nxt;
    bit nk;
    if (!rst_n) begin
      rq_b = '0; exp_b = '0; rqk_b = 1; expk_b = 1;
    end else begin
      nxt = rq_b; nk = rqk_b;
      if (en_b) begin nxt = mem_m[addr_b]; nk = known_m[addr_b]; end
      if (en_b && we_b) begin
        for (int l = 0; l < LANES; l++)
          if (be_b[l]) mem_m[addr_b][l*LW +: LW] = wdata_b[l*LW +: LW];
        if (&be_b) known_m[addr_b] = 1;
      end
      if (OREG_B) begin exp_b = rq_b; expk_b = rqk_b; end
      else        begin exp_b = nxt;  expk_b = nk;    end
      rq_b = nxt; rqk_b = nk;
    end
  end

  always @(negedge clk_a) if (rst_n && expk_a) check(rdata_a === exp_a, cur_req, "port A", rdata_a, exp_a);
  always @(negedge clk_b) if (rst_n && expk_b) check(rdata_b === exp_b, cur_req, "port B", rdata_b, exp_b);

  task automatic op_a(input bit en, input bit we, input logic [LANES-1:0] be,
                      input int addr, input logic [W-1:0] d);
    @(negedge clk_a);
    en_a = en; we_a = we; be_a = be; addr_a = AW'(addr); wdata_a = d;
  endtask
  task automatic op_b(input bit en, input bit we, input logic [LANES-1:0] be,
                      input int addr, input logic [W-1:0] d);
    @(negedge clk_b);
    en_b = en; we_b = we; be_b = be; addr_b = AW'(addr); wdata_b = d;
  endtask
  task automatic idle_a(input int n);
    for (int i = 0; i < n; i++) begin @(negedge clk_a); en_a = 0; we_a = 0; end
  endtask
  task automatic idle_b(input int n);
    for (int i = 0; i < n; i++) begin @(negedge clk_b); en_b = 0; we_b = 0; end
  endtask

  function automatic logic [W-1:0] pat(input int i, input int salt);
    return W'((i * 1103 + salt * 4099) ^ 'h2B3C5);
  endfunction

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(CLK_A_PERIOD * 100000);
    checks++; fails++;
    $display("FAIL watchdog: run did not complete, actual=hung expected=done");
    finish_run();
  end

  initial begin
    #1 rst_n = 0;
    @(negedge clk_a); @(negedge clk_a);
    check(rdata_a == '0, "R1", "port A in reset", rdata_a, '0);
    check(rdata_b == '0, "R1", "port B in reset", rdata_b, '0);
    #(31 - $time) rst_n = 1;
    idle_a(3); idle_b(2);
    check(rdata_a == '0, "R1", "port A after reset", rdata_a, '0);
    check(rdata_b == '0, "R1", "port B after reset", rdata_b, '0);

    cur_req = "R2";
    for (int i = 0; i < DEPTH; i++) op_a(1, 1, 2'b11, i, pat(i, 0));
    for (int i = 0; i < DEPTH; i++) op_a(1, 0, 2'b00, i, '0);
    idle_a(3);

    cur_req = "R7";
    for (int i = 0; i < DEPTH; i++) op_b(1, 0, 2'b00, DEPTH - 1 - i, '0);
    idle_b(4);

    cur_req = "R4";
    for (int i = 0; i < 8; i++) begin op_a(1, 0, 0, i * 3, '0); idle_a(2); end
    for (int i = 0; i < 8; i++) begin op_b(1, 0, 0, i * 5, '0); idle_b(3); end

    cur_req = "R3";
    for (int i = 0; i < 16; i++) begin
      op_a(1, 1, 2'b11, i * 7, pat(i, 1));
      op_a(1, 0, 2'b00, i * 7, '0);
    end
    idle_a(2);
    for (int i = 0; i < 16; i++) begin
      op_b(1, 1, 2'b11, 130 + i * 5, pat(i, 2));
      op_b(1, 0, 2'b00, 130 + i * 5, '0);
    end
    idle_b(3);

    cur_req = "R5";
    for (int i = 0; i < 8; i++) begin
      op_a(1, 1, 2'b11, 40 + i, pat(i, 3));
      op_a(1, 1, 2'b11, 40 + i, pat(i, 4));
    end
    idle_a(2);
    for (int i = 0; i < 8; i++) begin
      op_b(1, 1, 2'b11, 60 + i, pat(i, 5));
      op_b(1, 1, 2'b11, 60 + i, pat(i, 6));
    end
    idle_b(3);

    cur_req = "R6";
    op_a(1, 1, 2'b01, 80, 18'h3FFFF);
    op_a(1, 1, 2'b10, 81, 18'h3FFFF);
    op_a(1, 1, 2'b00, 82, 18'h3FFFF);
    op_a(1, 1, 2'b10, 83, 18'h00000);
    for (int i = 80; i < 84; i++) op_a(1, 0, 0, i, '0);
    idle_a(2);
    op_b(1, 1, 2'b01, 84, 18'h00000);
    op_b(1, 1, 2'b10, 85, 18'h3FE00);
    for (int i = 80; i < 86; i++) op_b(1, 0, 0, i, '0);
    idle_b(3);

    cur_req = "R9";
    op_a(1, 1, 2'b11, 100, 18'h15555); idle_a(2);
    op_b(1, 1, 2'b01, 100, 18'h0A0A0); idle_b(2);
    op_a(1, 0, 2'b00, 100, '0); idle_a(2);
    op_a(1, 1, 2'b10, 100, 18'h2AAAA); idle_a(2);
    op_b(1, 0, 2'b00, 100, '0); idle_b(3);
    op_b(1, 1, 2'b10, 101, 18'h3C000); idle_b(2);
    op_a(1, 1, 2'b01, 101, 18'h001E3); idle_a(2);
    op_b(1, 0, 2'b00, 101, '0); idle_b(3);
    op_a(1, 0, 2'b00, 101, '0); idle_a(2);

    cur_req = "R8";
    op_a(1, 0, 0, 120, '0);
    op_a(0, 1, 2'b11, 120, 18'h12345);
    op_a(0, 0, 2'b11, 7, '0);
    idle_a(3);
    op_a(1, 0, 0, 120, '0); idle_a(3);
    op_b(1, 0, 0, 121, '0);
    op_b(0, 1, 2'b11, 121, 18'h2FEDC);
    idle_b(4);
    op_b(1, 0, 0, 121, '0); idle_b(4);

    cur_req = "R7";
    fork
      for (int i = 0; i < 300; i++)
        op_a(1, 1'($urandom_range(1)), 2'($urandom_range(3)), $urandom_range(127), W'($urandom));
      for (int i = 0; i < 300; i++)
        op_b(1, 1'($urandom_range(1)), 2'($urandom_range(3)), 128 + $urandom_range(127), W'($urandom));
    join
    idle_a(2); idle_b(3);
    for (int i = 0; i < DEPTH; i += 3) op_a(1, 0, 0, i, '0);
    idle_a(2);
    for (int i = 1; i < DEPTH; i += 3) op_b(1, 0, 0, i, '0);
    idle_b(4);
    idle_a(2);

    finish_run();
  end
endmodule